// File: doc/BRIEF.md
# Standby Wake Controller

This block sequences the return from a clock-stopped standby state. Software asks for standby by holding a standby-request bit and issuing a sleep command. The block then gates the system clock off and drives the status outputs to the standby code. While in standby it watches every wake source. Each maskable request is compared against the current 4-bit interrupt mask. NMI always passes that comparison. A request from the interval timer never wakes the chip. In real-time-clock-only operation, only a reduced set of sources is allowed to wake it.

When a request qualifies, the block loads an 8-bit settling counter from a programmed start value. The counter is clocked through a selectable prescaler tap. The clock stays off until the counter overflows. At that point the clock enable returns, the status outputs go to the running code, and the event code of the winning source is latched. If software leaves the standby-request bit set, the counter keeps running. The block drops back into standby once the counter reaches 0x80. Clearing the bit stops the counter, and the chip stays running. An active-low power-on reset always cancels standby.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After power-on reset, `clk_en_o` is 1, `status_o` is 2'b00 and `evt_code_o` is 8'h00.
- R2: In the running state, a cycle with `sleep_i` and `stby_req_i` both high enters standby: after that edge `clk_en_o` is 0 and `status_o` is 2'b11. `sleep_i` with `stby_req_i` low has no effect.
- R3: A maskable request wakes the chip only when its 4-bit level is strictly greater than `imask_i`. The IRL input requests at level `irl_i`, and 0 means no request. NMI counts as level 16 and always passes.
- R4: Peripheral line 0 (the interval timer) never wakes the chip, whatever its level.
- R5: With `rtc_only_i` high, only these sources can wake the chip: IRL, IRQ lines 0 to 4, pin lines 0 to 5, and peripheral lines 1 (RTC) and 2 (timer unit). NMI, IRQ 5, pin lines 6 and 7, and peripheral line 3 are ignored.
- R6: The clock stays off while the counter settles. `clk_en_o` is first seen high (256 - `cnt_init_i`) * 2^`cks_i` cycles after the edge that samples the wake request. Requests that arrive during settling do not change this timing.
- R7: `status_o` is 2'b00 whenever `clk_en_o` is 1, and 2'b11 whenever it is 0.
- R8: The event code of the winning source is latched when the clock returns, and it holds while the chip runs. The codes are: NMI 8'h10; IRL 8'h20 + level; IRQ line i 8'h40 + i; pin line i 8'h60 + i; peripheral line i 8'h80 + i. The highest level wins. On a tie the earlier source wins, in the order NMI, IRL, IRQ ascending, pin ascending, peripheral ascending.
- R9: If `stby_req_i` stays high after wake-up, the chip re-enters standby 128 * 2^`cks_i` cycles after the clock returns. If `stby_req_i` is low, the next edge returns the block to the plain running state, and it stays there.
- R10: Asserting `rst_ni` during standby or settling returns the chip to the running state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sleep_i | input | 1 | Sleep command pulse |
| stby_req_i | input | 1 | Standby-request bit |
| rtc_only_i | input | 1 | Chip runs from the RTC source only |
| imask_i | input | 4 | Interrupt mask level |
| cks_i | input | 3 | Prescaler tap select (tick every 2^cks cycles) |
| cnt_init_i | input | 8 | Settling counter start value |
| nmi_i | input | 1 | Non-maskable request |
| irl_i | input | 4 | Encoded request level, 0 = none |
| irq_i | input | 6 | External request lines |
| irq_lvl_i | input | 24 | 4-bit level per IRQ line |
| pint_i | input | 8 | Pin-change request lines |
| pint_lvl_i | input | 4 | Shared level of the pin lines |
| per_i | input | 4 | Peripheral request lines |
| per_lvl_i | input | 16 | 4-bit level per peripheral line |
| clk_en_o | output | 1 | System clock enable |
| status_o | output | 2 | Status pins (00 running, 11 standby) |
| evt_code_o | output | 8 | Latched wake event code |

## Verification
The bench uses the default parameters: six IRQ lines, eight pin lines, four peripheral lines, and the RTC-mode limits of five IRQ and six pin lines. These defaults let every excluded line in RTC-only mode, and the interval-timer line, be driven directly. The bench limits `cks_i` to 0..2 and the start value to 0xC0 or higher in the random part, so each settling and re-entry window ends in a few hundred cycles. Exact cycle counts can then be compared for every tap. One directed case uses a zero start value and the slowest tap, which leaves time to apply reset in the middle of settling.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;
  localparam int LVL_W = 5;
  localparam int EVT_W = 8;
  localparam logic [LVL_W-1:0] NMI_LVL = 5'd16;

  localparam logic [EVT_W-1:0] CODE_NMI  = 8'h10;
  localparam logic [EVT_W-1:0] CODE_IRL  = 8'h20;
  localparam logic [EVT_W-1:0] CODE_IRQ  = 8'h40;
  localparam logic [EVT_W-1:0] CODE_PINT = 8'h60;
  localparam logic [EVT_W-1:0] CODE_PER  = 8'h80;

  localparam logic [1:0] STAT_RUN  = 2'b00;
  localparam logic [1:0] STAT_STBY = 2'b11;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_STBY,
    ST_SETTLE,
    ST_WATCH
  } wk_state_e;
endpackage

// File: rtl/stby_wake_arb.sv
module stby_wake_arb import stby_wake_pkg::*; #(
  parameter int N_IRQ    = 6,
  parameter int N_PINT   = 8,
  parameter int N_PER    = 4,
  parameter int ITI_IDX  = 0,
  parameter int RTC_IDX  = 1,
  parameter int TMU_IDX  = 2,
  parameter int IRQ_RTC  = 5,
  parameter int PINT_RTC = 6
) (
  input  logic               rtc_only_i,
  input  logic [3:0]         imask_i,
  input  logic               nmi_i,
  input  logic [3:0]         irl_i,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic [4*N_IRQ-1:0] irq_lvl_i,
  input  logic [N_PINT-1:0]  pint_i,
  input  logic [3:0]         pint_lvl_i,
  input  logic [N_PER-1:0]   per_i,
  input  logic [4*N_PER-1:0] per_lvl_i,
  output logic               win_vld_o,
  output logic [LVL_W-1:0]   win_lvl_o,
  output logic [EVT_W-1:0]   win_code_o
);
  localparam int IRQ_B  = 2;
  localparam int PINT_B = IRQ_B + N_IRQ;
  localparam int PER_B  = PINT_B + N_PINT;
  localparam int N_SRC  = PER_B + N_PER;

  logic             src_ok   [N_SRC];
  logic [LVL_W-1:0] src_lvl  [N_SRC];
  logic [EVT_W-1:0] src_code [N_SRC];

  assign src_ok[0]   = nmi_i && !rtc_only_i;
  assign src_lvl[0]  = NMI_LVL;
  assign src_code[0] = CODE_NMI;

  assign src_ok[1]   = (irl_i != 4'd0);
  assign src_lvl[1]  = {1'b0, irl_i};
  assign src_code[1] = CODE_IRL + {4'd0, irl_i};

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    localparam bit RTC_OK = (i < IRQ_RTC);
    assign src_ok[IRQ_B+i]   = irq_i[i] && (!rtc_only_i || RTC_OK);
    assign src_lvl[IRQ_B+i]  = {1'b0, irq_lvl_i[4*i +: 4]};
    assign src_code[IRQ_B+i] = CODE_IRQ + EVT_W'(i);
  end

  for (genvar i = 0; i < N_PINT; i++) begin : g_pint
    localparam bit RTC_OK = (i < PINT_RTC);
    assign src_ok[PINT_B+i]   = pint_i[i] && (!rtc_only_i || RTC_OK);
    assign src_lvl[PINT_B+i]  = {1'b0, pint_lvl_i};
    assign src_code[PINT_B+i] = CODE_PINT + EVT_W'(i);
  end

  for (genvar i = 0; i < N_PER; i++) begin : g_per
    localparam bit NEVER  = (i == ITI_IDX);
    localparam bit RTC_OK = (i == RTC_IDX) || (i == TMU_IDX);
    assign src_ok[PER_B+i]   = per_i[i] && !NEVER && (!rtc_only_i || RTC_OK);
    assign src_lvl[PER_B+i]  = {1'b0, per_lvl_i[4*i +: 4]};
    assign src_code[PER_B+i] = CODE_PER + EVT_W'(i);
  end

  // strict compare keeps the earliest source on a level tie
  always_comb begin
    win_vld_o  = 1'b0;
    win_lvl_o  = '0;
    win_code_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (src_ok[s] && (src_lvl[s] > {1'b0, imask_i}) &&
          (!win_vld_o || (src_lvl[s] > win_lvl_o))) begin
        win_vld_o  = 1'b1;
        win_lvl_o  = src_lvl[s];
        win_code_o = src_code[s];
      end
    end
  end
endmodule

// File: rtl/stby_wake_cnt.sv
module stby_wake_cnt #(
  parameter int CNT_W = 8,
  parameter int CKS_W = 3,
  parameter int HIT   = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             ovf_o,
  output logic             hit_o
);
  localparam int PS_W = (1 << CKS_W) - 1;

  logic [PS_W-1:0]  presc_q;
  logic [PS_W-1:0]  tap_msk;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  always_comb begin
    for (int b = 0; b < PS_W; b++) tap_msk[b] = (b < int'(cks_i));
  end

  assign tick  = &(presc_q | ~tap_msk);
  assign ovf_o = run_i && tick && (cnt_q == '1);
  assign hit_o = run_i && tick && (cnt_q == CNT_W'(HIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    presc_q <= '0;
    else if (clr_i) presc_q <= '0;
    else            presc_q <= presc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (run_i && tick) cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_ON_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl import stby_wake_pkg::*; #(
  parameter int N_IRQ    = 6,
  parameter int N_PINT   = 8,
  parameter int N_PER    = 4,
  parameter int ITI_IDX  = 0,
  parameter int RTC_IDX  = 1,
  parameter int TMU_IDX  = 2,
  parameter int IRQ_RTC  = 5,
  parameter int PINT_RTC = 6,
  parameter int CNT_W    = 8,
  parameter int CKS_W    = 3,
  parameter int REENTRY  = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_i,
  input  logic               stby_req_i,
  input  logic               rtc_only_i,
  input  logic [3:0]         imask_i,
  input  logic [CKS_W-1:0]   cks_i,
  input  logic [CNT_W-1:0]   cnt_init_i,
  input  logic               nmi_i,
  input  logic [3:0]         irl_i,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic [4*N_IRQ-1:0] irq_lvl_i,
  input  logic [N_PINT-1:0]  pint_i,
  input  logic [3:0]         pint_lvl_i,
  input  logic [N_PER-1:0]   per_i,
  input  logic [4*N_PER-1:0] per_lvl_i,
  output logic               clk_en_o,
  output logic [1:0]         status_o,
  output logic [EVT_W-1:0]   evt_code_o
);
  wk_state_e        state_q, state_d;
  logic             wake_vld;
  logic [LVL_W-1:0] win_lvl;
  logic [EVT_W-1:0] win_code;
  logic [EVT_W-1:0] pend_q;
  logic             cnt_ovf, cnt_hit, cnt_run, cnt_clr, cnt_load;

  stby_wake_arb #(
    .N_IRQ(N_IRQ), .N_PINT(N_PINT), .N_PER(N_PER), .ITI_IDX(ITI_IDX),
    .RTC_IDX(RTC_IDX), .TMU_IDX(TMU_IDX), .IRQ_RTC(IRQ_RTC), .PINT_RTC(PINT_RTC)
  ) u_arb (
    .rtc_only_i(rtc_only_i), .imask_i(imask_i), .nmi_i(nmi_i), .irl_i(irl_i),
    .irq_i(irq_i), .irq_lvl_i(irq_lvl_i), .pint_i(pint_i), .pint_lvl_i(pint_lvl_i),
    .per_i(per_i), .per_lvl_i(per_lvl_i),
    .win_vld_o(wake_vld), .win_lvl_o(win_lvl), .win_code_o(win_code)
  );

  assign cnt_clr  = (state_q == ST_RUN) || (state_q == ST_STBY);
  assign cnt_load = (state_q == ST_STBY) && wake_vld;
  assign cnt_run  = (state_q == ST_SETTLE) || ((state_q == ST_WATCH) && stby_req_i);

  stby_wake_cnt #(.CNT_W(CNT_W), .CKS_W(CKS_W), .HIT(REENTRY)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .load_i(cnt_load),
    .load_val_i(cnt_init_i), .run_i(cnt_run), .cks_i(cks_i),
    .ovf_o(cnt_ovf), .hit_o(cnt_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (sleep_i && stby_req_i) state_d = ST_STBY;
      ST_STBY:   if (wake_vld) state_d = ST_SETTLE;
      ST_SETTLE: if (cnt_ovf) state_d = ST_WATCH;
      ST_WATCH: begin
        if (!stby_req_i)  state_d = ST_RUN;
        else if (cnt_hit) state_d = ST_STBY;
      end
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      evt_code_o <= '0;
    end else begin
      if (cnt_load) pend_q <= win_code;
      if ((state_q == ST_SETTLE) && cnt_ovf) evt_code_o <= pend_q;
    end
  end

  assign clk_en_o = (state_q == ST_RUN) || (state_q == ST_WATCH);
  assign status_o = clk_en_o ? STAT_RUN : STAT_STBY;

  AST_HOLD_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_STBY) && !wake_vld) |=> (state_q == ST_STBY)); // R3
  AST_WIN_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_vld |-> (win_lvl > {1'b0, imask_i})); // R3
  AST_NO_ITI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_i && (irl_i == 4'd0) && (irq_i == '0) && (pint_i == '0) &&
     (per_i == N_PER'(1 << ITI_IDX))) |-> !wake_vld); // R4
  AST_SETTLE_CLK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SETTLE) && !cnt_ovf) |=> !clk_en_o); // R6
  AST_EVT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> $stable(evt_code_o)); // R8
  AST_CLR_STAYS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WATCH) && !stby_req_i) |=> (clk_en_o && (status_o == STAT_RUN))); // R9
endmodule

// File: tb/stby_wake_ctrl_bench.sv
module stby_wake_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sleep_i = 1'b0, stby_req_i = 1'b0, rtc_only_i = 1'b0;
  logic [3:0]  imask_i = '0;
  logic [2:0]  cks_i = '0;
  logic [7:0]  cnt_init_i = 8'hF0;
  logic        nmi_i = 1'b0;
  logic [3:0]  irl_i = '0;
  logic [5:0]  irq_i = '0;
  logic [23:0] irq_lvl_i = '0;
  logic [7:0]  pint_i = '0;
  logic [3:0]  pint_lvl_i = '0;
  logic [3:0]  per_i = '0;
  logic [15:0] per_lvl_i = '0;
  logic        clk_en_o;
  logic [1:0]  status_o;
  logic [7:0]  evt_code_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  stby_wake_ctrl u_stby_wake_ctrl (.*);

  always #10 clk_i = ~clk_i;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (R1..R10 flow) act=%0d exp<%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic clr_src();
    nmi_i = 0; irl_i = 0; irq_i = 0; pint_i = 0; per_i = 0; rtc_only_i = 0;
  endtask

  task automatic do_reset();
    clr_src(); sleep_i = 0; stby_req_i = 0;
    @(negedge clk_i); rst_ni = 0;
    step(); step();
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic enter_stby();
    stby_req_i = 1; sleep_i = 1;
    step();
    sleep_i = 0;
    check("R2 clk_en after sleep", clk_en_o, 0);
    check("R2 status in standby", status_o, 2'b11);
  endtask

  function automatic void take(input int lvl, input bit ok, input logic [7:0] code,
                               inout int best, inout bit f, inout logic [7:0] c);
    if (ok && lvl > imask_i && (!f || lvl > best)) begin
      best = lvl; f = 1; c = code;
    end
  endfunction

  function automatic logic [8:0] exp_wake();
    int best = 0; bit f = 0; logic [7:0] c = 0;
    take(16, nmi_i && !rtc_only_i, 8'h10, best, f, c);
    take(int'(irl_i), irl_i != 0, 8'h20 + 8'(irl_i), best, f, c);
    for (int i = 0; i < 6; i++)
      take(int'(irq_lvl_i[4*i +: 4]), irq_i[i] && (!rtc_only_i || i < 5), 8'(8'h40 + i), best, f, c);
    for (int i = 0; i < 8; i++)
      take(int'(pint_lvl_i), pint_i[i] && (!rtc_only_i || i < 6), 8'(8'h60 + i), best, f, c);
    for (int i = 0; i < 4; i++)
      take(int'(per_lvl_i[4*i +: 4]), per_i[i] && i != 0 && (!rtc_only_i || i == 1 || i == 2),
           8'(8'h80 + i), best, f, c);
    return {f, c};
  endfunction

  // drive current sources for one edge, return cycles until clock returns
  task automatic attempt(input int lim, output int n);
    step();
    clr_src();
    n = 1;
    while (!clk_en_o && n < lim) begin
      step(); n++;
    end
  endtask

  function automatic int settle_len(input logic [7:0] init, input logic [2:0] k);
    return 1 + ((256 - int'(init)) << k);
  endfunction

  // enter standby, wake with given sources, check timing/code, leave running
  task automatic wake_case(input string tag, input logic [7:0] init, input logic [2:0] k,
                           input bit keep_req);
    logic [8:0] e;
    int n, exp_n;
    cnt_init_i = init; cks_i = k;
    e = exp_wake();
    exp_n = settle_len(init, k);
    attempt(exp_n + 4, n);
    if (e[8]) begin
      check({tag, " R6 settle cycles"}, n, exp_n);
      check({tag, " R7 status on wake"}, status_o, 2'b00);
      check({tag, " R8 event code"}, evt_code_o, e[7:0]);
      if (!keep_req) begin
        stby_req_i = 0; step(); step();
        check({tag, " R9 stays running"}, clk_en_o, 1);
      end
    end else begin
      check({tag, " R3 no wake"}, clk_en_o, 0);
      do_reset();
      check({tag, " R10 reset leaves standby"}, clk_en_o, 1);
    end
  endtask

  initial begin
    logic [8:0] e;
    int n;
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 clk_en reset", clk_en_o, 1);
    check("R1 status reset", status_o, 2'b00);
    check("R1 evt reset", evt_code_o, 0);

    // R2: sleep without the request bit is ignored
    sleep_i = 1; stby_req_i = 0; step(); sleep_i = 0;
    check("R2 sleep ignored", clk_en_o, 1);
    check("R2 status ignored", status_o, 2'b00);

    // NMI wake, keep request bit, then re-entry after 128 ticks (R9)
    enter_stby();
    imask_i = 4'hF; nmi_i = 1;
    wake_case("nmi", 8'hF0, 3'd0, 1);
    n = 0;
    while (clk_en_o && n < 600) begin step(); n++; end
    check("R9 re-entry cycles k0", n, 128);
    check("R7 status after re-entry", status_o, 2'b11);
    irl_i = 4'd9; imask_i = 4'd3;
    wake_case("irl", 8'hFC, 3'd1, 1);
    n = 0;
    while (clk_en_o && n < 600) begin step(); n++; end
    check("R9 re-entry cycles k1", n, 256);
    nmi_i = 1;
    wake_case("nmi2", 8'hFE, 3'd0, 0);
    repeat (300) step();
    check("R9 cleared bit keeps clock", clk_en_o, 1);

    // R3 mask boundary
    enter_stby(); imask_i = 4'd5; irq_i = 6'b000100; irq_lvl_i = 24'h000500;
    wake_case("irq2 lvl=mask", 8'hF8, 3'd0, 0);
    enter_stby(); imask_i = 4'd5; irq_i = 6'b000100; irq_lvl_i = 24'h000600;
    wake_case("irq2 lvl>mask", 8'hF8, 3'd0, 0);
    check("R8 irq2 code", evt_code_o, 8'h42);
    // R8 tie order
    enter_stby(); imask_i = 4'd0; irq_i = 6'b001010; irq_lvl_i = 24'h009090;
    pint_i = 8'h08; pint_lvl_i = 4'd9;
    wake_case("tie", 8'hFA, 3'd2, 0);
    check("R8 tie winner", evt_code_o, 8'h41);
    // R4 interval timer never wakes
    enter_stby(); imask_i = 4'd0; per_i = 4'b0001; per_lvl_i = 16'h000F;
    wake_case("R4 iti", 8'hF0, 3'd0, 0);
    // R5 rtc-only filtering
    enter_stby(); rtc_only_i = 1; nmi_i = 1; imask_i = 0;
    wake_case("R5 nmi", 8'hF0, 3'd0, 0);
    enter_stby(); rtc_only_i = 1; irq_i = 6'b100000; irq_lvl_i = 24'hF00000;
    pint_i = 8'hC0; pint_lvl_i = 4'hF; per_i = 4'b1000; per_lvl_i = 16'hF000;
    wake_case("R5 excluded", 8'hF0, 3'd0, 0);
    enter_stby(); rtc_only_i = 1; irq_i = 6'b010000; irq_lvl_i = 24'h0A0000;
    per_i = 4'b0010; per_lvl_i = 16'h00B0;
    wake_case("R5 allowed", 8'hF0, 3'd1, 0);
    check("R5 per1 wins", evt_code_o, 8'h81);

    // R6 late request during settle does not change timing or code
    enter_stby(); imask_i = 0; pint_i = 8'h01; pint_lvl_i = 4'd2;
    cnt_init_i = 8'hF0; cks_i = 0;
    step(); clr_src();
    repeat (4) step();
    nmi_i = 1; step(); nmi_i = 0;
    n = 6;
    while (!clk_en_o && n < 40) begin step(); n++; end
    check("R6 settle ignores late req", n, 17);
    check("R8 late req code", evt_code_o, 8'h60);
    stby_req_i = 0; step();

    // R10 reset mid-settle
    enter_stby(); nmi_i = 1; cnt_init_i = 8'h00; cks_i = 3'd2;
    step(); clr_src();
    repeat (50) step();
    check("R6 still settling", clk_en_o, 0);
    do_reset();
    check("R10 reset mid settle", clk_en_o, 1);
    check("R10 evt after reset", evt_code_o, 0);

    // constrained random
    for (int it = 0; it < 60; it++) begin
      enter_stby();
      imask_i    = 4'($urandom % 16);
      rtc_only_i = ($urandom % 4) == 0;
      nmi_i      = ($urandom % 8) == 0;
      irl_i      = (($urandom % 3) == 0) ? 4'($urandom) : 4'd0;
      irq_i      = 6'($urandom & $urandom);
      irq_lvl_i  = 24'($urandom);
      pint_i     = 8'($urandom & $urandom & $urandom);
      pint_lvl_i = 4'($urandom);
      per_i      = 4'($urandom & $urandom);
      per_lvl_i  = 16'($urandom);
      e = exp_wake();
      wake_case($sformatf("rnd%0d R3/R8", it), 8'hC0 | 8'($urandom % 64), 3'($urandom % 3), 0);
      if (e[8]) check($sformatf("rnd%0d R8 code", it), evt_code_o, e[7:0]);
    end

    summary();
    $finish;
  end
endmodule